// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout and Power-On Hold

This block watches for signs of life from software. Once armed, it counts pulses of a slow tick input that stands in for a free-running low-frequency oscillator. If software does not refresh it before a chosen number of ticks has elapsed, it raises a one-clock reset request. The timeout is picked by a two-bit code. The steps between codes are uneven: the longest setting is sixteen times the base, not eight. A keep-running bit decides what happens while the core is stopped. When the bit is clear, the count freezes during stop. When it is set, the count goes on.

The block also contains a power-on hold. After reset it keeps a hold output high until a fixed number of ticks has been seen, and the watchdog stays quiet during that time. The block has no data stream. Every pin is a plain level or a strobe sampled on the rising clock edge. There is no valid/ready handshake and so no back-pressure.

Top module: `wdog_top`

## Requirements
- R1: After reset `bite_o` is 0, `por_hold_o` is 1, the timeout code is 00, keep-running is clear and the watchdog is disarmed. While disarmed it never raises `bite_o`, whatever the tick, enable and refresh inputs do.
- R2: A clock with `mode_we_i` high loads the timeout code from `mode_wdata_i[1:0]` and the keep-running bit from `mode_wdata_i[2]`. The first such write arms the watchdog, and it stays armed until reset.
- R3: With base exponent N, code 00 times out after 2^N counted ticks, code 01 after 2^(N+1), code 10 after 2^(N+2) and code 11 after 2^(N+4).
- R4: A tick is counted only on a clock where `tick_i` is high, the watchdog is armed, `en_i` is high and the power-on hold has ended. On other clocks the count holds.
- R5: `bite_o` is registered. It is high for exactly one clock, namely the clock after the edge that counted the terminal tick. The count restarts from zero at that edge.
- R6: `kick_i` clears the count to zero on any clock. A refresh on the same edge as the terminal tick wins: no `bite_o` follows.
- R7: While `stop_i` is high and keep-running is clear, the count freezes. With keep-running set, `stop_i` has no effect.
- R8: `por_hold_o` stays high after reset until POR_TICKS clocks with `tick_i` high have passed. It falls in the clock after the last of them and stays low until the next reset.
- R9: If a mode write selects a shorter timeout while the count is already at or past the new terminal value, the next counted tick raises `bite_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow time base; one count per clock it is high |
| kick_i | input | 1 | Refresh strobe from software |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 3 | [1:0] timeout code, [2] keep-running in stop |
| en_i | input | 1 | Counting enable |
| stop_i | input | 1 | Core is in stop mode |
| bite_o | output | 1 | One-clock reset request on timeout |
| por_hold_o | output | 1 | Power-on hold, high until the delay has elapsed |

## Verification
On every cycle, the embedded assertions check four things. The reset request is never wider than one clock. A refresh always leaves the count at zero and suppresses the request. A stopped count without keep-running does not move. The power-on hold never returns once it has fallen, and no request appears while it is high or while the watchdog is disarmed.

Only the bench's scenarios can show the exact interval for each of the four codes. The same holds for:
- refresh priority at the terminal tick;
- resuming a frozen count from where it stopped;
- the effect of sparse ticks;
- shrinking the timeout past the current count.

For these, a behavioural reference model is compared with both outputs on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int MODE_W = 3;
  typedef logic [1:0] wd_sel_t;

  // Exponent step above the base for each timeout code (uneven on purpose).
  function automatic logic [2:0] sel_shift(input wd_sel_t s);
    case (s)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/wdog_por.sv
module wdog_por #(
  parameter int POR_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic hold_o
);
  localparam int PW = $clog2(POR_TICKS + 1);
  localparam logic [PW-1:0] LAST = PW'(POR_TICKS - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_o <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_o && tick_i) begin
      if (cnt_q == LAST) hold_o <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: once released, the hold never comes back before a reset
  a_r8_hold_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_o |=> !hold_o);
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  output wd_sel_t           sel_o,
  output logic              keep_o,
  output logic              armed_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_o   <= 2'd0;
      keep_o  <= 1'b0;
      armed_o <= 1'b0;
    end else if (mode_we_i) begin
      sel_o   <= mode_wdata_i[1:0];
      keep_o  <= mode_wdata_i[2];
      armed_o <= 1'b1;
    end
  end

  // R2: a write arms the watchdog, and arming is sticky
  a_r2_write_arms: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we_i |=> armed_o);
  a_r2_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o |=> armed_o);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 12
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick_i,
  input  logic    kick_i,
  input  logic    run_i,
  input  wd_sel_t sel_i,
  output logic    bite_o
);
  localparam int CW = BASE_LOG2 + 4;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term;
  logic          hit;

  // Terminal value 2^(BASE_LOG2+shift)-1 from an all-ones word.
  always_comb begin
    term = {CW{1'b1}} >> (3'd4 - sel_shift(sel_i));
    hit  = (cnt_q >= term);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bite_o <= 1'b0;
    end else begin
      bite_o <= 1'b0;
      if (kick_i) begin
        cnt_q <= '0;
      end else if (run_i && tick_i) begin
        if (hit) begin
          cnt_q  <= '0;
          bite_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R5: reset request is a single-clock pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bite_o |=> !bite_o);
  // R6: refresh zeroes the count and suppresses a request
  a_r6_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_q == '0) && !bite_o);
  // R4/R7: without permission to run the count is frozen
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !kick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int POR_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              kick_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              en_i,
  input  logic              stop_i,
  output logic              bite_o,
  output logic              por_hold_o
);
  wd_sel_t sel;
  logic    keep, armed, run;

  wdog_por #(.POR_TICKS(POR_TICKS)) u_por (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hold_o(por_hold_o)
  );

  wdog_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i),
    .sel_o(sel), .keep_o(keep), .armed_o(armed)
  );

  // Counting permission: armed, enabled, past power-on, and not frozen by stop.
  assign run = armed && en_i && !por_hold_o && !(stop_i && !keep);

  wdog_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .kick_i(kick_i),
    .run_i(run), .sel_i(sel), .bite_o(bite_o)
  );

  // R8: no request during the power-on hold
  a_r8_quiet_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    por_hold_o |-> !bite_o);
  // R1: a disarmed watchdog stays silent
  a_r1_disarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !bite_o);
endmodule

// File: tb/wdog_top_test.sv
`timescale 1ns/1ps
module wdog_top_test;
  localparam int N   = 3;
  localparam int POR = 5;

  logic clk = 0, rst_n = 0;
  logic tick_i = 0, kick_i = 0, mode_we_i = 0, en_i = 0, stop_i = 0;
  logic [2:0] mode_wdata_i = '0;
  logic bite_o, por_hold_o;

  int tests = 0, fails = 0, cyc = 0, tcnt = 0, tick_div = 1;
  string cur = "R1";

  wdog_top #(.BASE_LOG2(N), .POR_TICKS(POR)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .kick_i(kick_i),
    .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i), .en_i(en_i),
    .stop_i(stop_i), .bite_o(bite_o), .por_hold_o(por_hold_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Behavioural reference model
  int m_cnt, m_por, m_hold, m_code, m_keep, m_arm, m_bite;
  function automatic int lim_of(int c);
    return (c == 3) ? (1 << (N + 4)) : (1 << (N + c));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_por = 0; m_hold = 1; m_code = 0; m_keep = 0; m_arm = 0; m_bite = 0;
    end else begin
      int nb;
      bit go;
      nb = 0;
      go = m_arm && en_i && !m_hold && !(stop_i && !m_keep);
      if (kick_i) m_cnt = 0;
      else if (go && tick_i) begin
        if (m_cnt >= lim_of(m_code) - 1) begin m_cnt = 0; nb = 1; end
        else m_cnt++;
      end
      if (m_hold && tick_i) begin
        m_por++;
        if (m_por == POR) m_hold = 0;
      end
      if (mode_we_i) begin
        m_code = mode_wdata_i[1:0]; m_keep = mode_wdata_i[2]; m_arm = 1;
      end
      m_bite = nb;
    end
  end

  always @(negedge clk) begin
    cyc++;
    tcnt++;
    tick_i <= (tcnt % tick_div == 0);
    if (rst_n) begin
      chk(bite_o == m_bite, {cur, " bite vs model"}, bite_o, m_bite);
      chk(por_hold_o == m_hold, {cur, " hold vs model"}, por_hold_o, m_hold);
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired in %s actual=%0d expected=0", cur, cyc);
      finish_run();
    end
  end

  task automatic write_mode(input logic [2:0] d, input bit with_kick);
    mode_wdata_i = d; mode_we_i = 1; kick_i = with_kick;
    @(posedge clk); #1;
    mode_we_i = 0; kick_i = 0;
  endtask

  // Observe negedges numbered from..n after a clearing edge; bite only at n.
  task automatic bite_at(input int from, input int n, input string tag);
    for (int k = from; k <= n; k++) begin
      @(negedge clk);
      chk(bite_o == (k == n), tag, bite_o, (k == n));
    end
  endtask

  task automatic quiet(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(bite_o == 0, tag, bite_o, 0);
    end
  endtask

  initial begin
    int bites;
    repeat (3) @(negedge clk);
    cur = "R1";
    chk(bite_o == 0, "R1 reset bite", bite_o, 0);
    chk(por_hold_o == 1, "R1 reset hold", por_hold_o, 1);
    rst_n = 1; en_i = 1;

    cur = "R8";
    for (int k = 1; k <= POR; k++) begin
      @(negedge clk);
      chk(por_hold_o == (k < POR), "R8 hold release", por_hold_o, (k < POR));
    end

    cur = "R1";
    quiet(100, "R1 disarmed silent");

    cur = "R3";
    for (int c = 0; c < 4; c++) begin
      write_mode(3'(c), 1);
      bite_at(0, lim_of(c), $sformatf("R3 code %0d interval", c));
    end

    cur = "R5";
    write_mode(3'd0, 1);
    bite_at(0, 8, "R5 first bite");
    bite_at(1, 8, "R5 restart from zero");

    cur = "R6";
    write_mode(3'd0, 1);
    quiet(8, "R6 before terminal");
    kick_i = 1;
    @(negedge clk);
    chk(bite_o == 0, "R6 kick beats terminal", bite_o, 0);
    kick_i = 0;
    bite_at(1, 8, "R6 after priority kick");

    cur = "R7";
    write_mode(3'd0, 1);
    quiet(5, "R7 pre-stop");
    stop_i = 1;
    quiet(30, "R7 frozen in stop");
    stop_i = 0;
    bite_at(1, 4, "R7 resumes frozen count");
    stop_i = 1;
    write_mode(3'b100, 1);
    bite_at(0, 8, "R7 keep-running in stop");
    stop_i = 0;

    cur = "R4";
    write_mode(3'd0, 1);
    quiet(3, "R4 pre-disable");
    en_i = 0;
    quiet(20, "R4 disabled holds");
    en_i = 1;
    bite_at(1, 6, "R4 resumes after enable");
    tick_div = 3;
    write_mode(3'd0, 1);
    bites = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      bites += bite_o;
    end
    chk(bites >= 3 && bites <= 5, "R4 sparse tick bite count", bites, 4);
    tick_div = 1;
    @(negedge clk);

    cur = "R9";
    write_mode(3'd2, 1);
    quiet(21, "R9 long count");
    mode_wdata_i = 3'd0; mode_we_i = 1;
    @(negedge clk);
    mode_we_i = 0;
    chk(bite_o == 0, "R9 write edge", bite_o, 0);
    @(negedge clk);
    chk(bite_o == 1, "R9 shrink bites next tick", bite_o, 1);

    cur = "R2";
    write_mode(3'd1, 1);
    bite_at(0, 16, "R2 code reloaded");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule